// File: doc/BRIEF.md
# External-clock serial result read port

This block returns a stored conversion result as a serial bit stream when a host supplies its own data clock. The host clock, chip select, read/convert, BUSY and tag pins are brought into the system clock domain through two-flop synchronizers. Rising edges of the data clock are then counted in that domain. The block drives one data line and one SYNC line. The result word and the BUSY status come from the conversion engine next to it. The engine replaces the word only when a conversion completes. A read made after BUSY rises therefore returns conversion n, and a read made while BUSY is low returns conversion n-1.

A frame can begin in one of two ways. If the data clock toggles while the port is idle, meaning chip select is high or chip select and read/convert are both low, a SYNC marker is armed. The next counted rising edge then raises SYNC for one pulse, and every data bit arrives one pulse later than it would otherwise. After the least significant bit, the data line shows the tag input. The tag is taken at the rising edge that presents the MSB, and the line holds that value until the port is cleared. The system clock must run at least four times faster than the data clock.

Top module: `xclk_readout`

## Requirements
- R1: While reset is asserted and immediately after it, sdata and sync_out are low.
- R2: A pin change is sampled at the next rising edge of clk, and the resulting output change appears just after the third rising edge of clk following the pin change.
- R3: Data-clock rising edges advance the frame only while ext_mode is high, sel_n is low and rd_conv is high. The frame position never goes past the tag slot.
- R4: With no SYNC armed, the first counted rising edge drives result bit 15 (the MSB) on sdata. Rising edge k drives bit 16-k, so the 16th edge drives bit 0 (the LSB).
- R5: result_word is captured at the edge that presents the MSB. Later changes to result_word do not alter the bits of the frame in progress.
- R6: A data-clock transition in either direction arms SYNC when the frame position is zero, ext_mode is high, and either sel_n is high or both sel_n and rd_conv are low.
- R7: With SYNC armed, rising edge 1 drives sync_out high and sdata low for one pulse. Rising edge 2 drives the MSB and lowers sync_out, and rising edge 17 drives the LSB.
- R8: After the LSB, the next rising edge puts the tag onto sdata. The tag value is the one tag_in had at rising edge 1 (no SYNC) or at rising edge 2 (SYNC). That level then holds, and further rising edges are ignored.
- R9: A rise of sel_n or a fall of busy clears the frame position and the SYNC arming. A clear outranks a counted edge that lands in the same cycle.
- R10: When the data clock runs continuously while sel_n is high, the frame that follows sel_n going low always starts with SYNC.
- R11: While ext_mode is low, data-clock edges neither advance a frame nor arm SYNC, and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | High selects external data clock operation (static strap) |
| dclk | input | 1 | Host data clock, asynchronous |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| rd_conv | input | 1 | High = read, low = convert, asynchronous |
| busy | input | 1 | Low while a conversion runs |
| tag_in | input | 1 | Tag bit appended after the LSB |
| result_word | input | 16 | Stored result from the conversion engine |
| sdata | output | 1 | Serial data: result bits MSB first, then tag |
| sync_out | output | 1 | One-pulse marker ahead of the MSB when armed |

## Verification
The hardest case to reach is a frame whose start depends on the exact edges the host produced while idle. One lone transition with rd_conv low must arm SYNC, yet a frame that stalls mid-word while rd_conv is low must not be armed. The stimulus builds both cases with single clock toggles. It also runs a free-running data clock across chip-select changes and changes tag_in between the first and second rising edges, so that the edge where the tag is taken is visible. A behavioural model tracks every pin sample and is compared on each system clock.

// File: rtl/xclk_readout_pkg.sv
package xclk_readout_pkg;
  typedef struct packed {
    logic dclk;
    logic sel_n;
    logic rdc;
    logic busy;
    logic tag;
  } pins_t;

  localparam pins_t PINS_IDLE = '{dclk: 1'b0, sel_n: 1'b1, rdc: 1'b1,
                                  busy: 1'b1, tag: 1'b0};
endpackage

// File: rtl/xclk_readout_sync.sv
module xclk_readout_sync #(
  parameter int N = 5,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_q
);
  logic [N-1:0] stage1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= RST[b];
        sync_q[b] <= RST[b];
      end else begin
        stage1[b] <= async_in[b];
        sync_q[b] <= stage1[b];
      end
    end
  end
endmodule

// File: rtl/xclk_readout_seq.sv
module xclk_readout_seq
  import xclk_readout_pkg::*;
#(
  parameter int W = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ext_mode,
  input  pins_t cur,
  output logic  load,
  output logic  shift,
  output logic  sync_ph,
  output logic  data_ph,
  output logic  tag_ph,
  output logic  tag_q
);
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] ZERO   = '0;
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] LAST_P = CW'(W + 1);
  localparam logic [CW-1:0] LAST_A = CW'(W + 2);

  logic [CW-1:0] cnt, last_c;
  logic armed;
  logic prev_dclk, prev_sel_n, prev_busy;
  logic dclk_rise, dclk_edge, clr, idle_cond, read_win, step, arm_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dclk  <= PINS_IDLE.dclk;
      prev_sel_n <= PINS_IDLE.sel_n;
      prev_busy  <= PINS_IDLE.busy;
    end else begin
      prev_dclk  <= cur.dclk;
      prev_sel_n <= cur.sel_n;
      prev_busy  <= cur.busy;
    end
  end

  always_comb begin
    dclk_rise = cur.dclk & ~prev_dclk;
    dclk_edge = cur.dclk ^ prev_dclk;
    clr       = (cur.sel_n & ~prev_sel_n) | (~cur.busy & prev_busy);
    idle_cond = ext_mode & (cur.sel_n | ~cur.rdc);
    read_win  = ext_mode & ~cur.sel_n & cur.rdc;
    arm_evt   = dclk_edge & idle_cond;
    last_c    = armed ? LAST_A : LAST_P;
    step      = ~clr & dclk_rise & read_win & (cnt < last_c);
    load      = step & (cnt == (armed ? ONE : ZERO));
    shift     = step & ~load;
    sync_ph   = armed & (cnt == ONE);
    tag_ph    = (cnt == last_c);
    data_ph   = (cnt != ZERO) & ~sync_ph & ~tag_ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= ZERO;
      armed <= 1'b0;
      tag_q <= 1'b0;
    end else if (clr) begin
      cnt   <= ZERO;
      armed <= arm_evt;
    end else begin
      if (step) cnt <= cnt + ONE;
      if (arm_evt && cnt == ZERO) armed <= 1'b1;
      if (load) tag_q <= cur.tag;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_c);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE));

  assert_arm_at_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> cnt == ZERO);

  assert_arm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != ZERO && !clr) |=> $stable(armed));

  assert_sync_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ph && step) |=> !sync_ph);

  assert_tag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_ph && !clr) |=> ($stable(tag_q) && $stable(cnt)));

  assert_mode_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !clr) |=> $stable(cnt));
endmodule

// File: rtl/xclk_readout_shift.sv
module xclk_readout_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word_in,
  output logic         msb
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= word_in;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign msb = sh[W-1];

  assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sh == $past(word_in));
endmodule

// File: rtl/xclk_readout.sv
module xclk_readout
  import xclk_readout_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_mode,
  input  logic         dclk,
  input  logic         sel_n,
  input  logic         rd_conv,
  input  logic         busy,
  input  logic         tag_in,
  input  logic [W-1:0] result_word,
  output logic         sdata,
  output logic         sync_out
);
  localparam int NP = $bits(pins_t);

  pins_t raw_p, cur_p;
  logic [NP-1:0] cur_v;
  logic load, shift, sync_ph, data_ph, tag_ph, tag_q, msb;

  assign raw_p = '{dclk: dclk, sel_n: sel_n, rdc: rd_conv, busy: busy, tag: tag_in};

  xclk_readout_sync #(.N(NP), .RST(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_p), .sync_q(cur_v));

  assign cur_p = pins_t'(cur_v);

  xclk_readout_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .cur(cur_p),
    .load(load), .shift(shift), .sync_ph(sync_ph), .data_ph(data_ph),
    .tag_ph(tag_ph), .tag_q(tag_q));

  xclk_readout_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .word_in(result_word), .msb(msb));

  assign sdata    = data_ph ? msb : (tag_ph & tag_q);
  assign sync_out = sync_ph;

  assert_sync_quiet_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> !sdata);
endmodule

// File: tb/test_xclk_readout.sv
module test_xclk_readout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 1'b1;
  logic dclk = 1'b0, sel_n = 1'b1, rd_conv = 1'b1, busy = 1'b1, tag_in = 1'b0;
  logic [15:0] result_word = 16'h0000;
  logic sdata, sync_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  xclk_readout i_xclk_readout (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .dclk(dclk), .sel_n(sel_n),
    .rd_conv(rd_conv), .busy(busy), .tag_in(tag_in), .result_word(result_word),
    .sdata(sdata), .sync_out(sync_out));

  // Behavioural reference: frame position as an integer, outputs delayed by
  // the pin-to-output latency of R2.
  int m_pos;
  bit m_arm, m_tag;
  logic [15:0] m_word;
  bit p_dclk, p_sel, p_busy;
  bit [1:0] d1, d2, exp_o;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_arm = 0; m_tag = 0; m_word = 0;
      p_dclk = 0; p_sel = 1; p_busy = 1;
      d1 = 0; d2 = 0; exp_o = 0;
    end else begin
      bit m_rise, m_edge, m_clr, m_idle, m_win;
      int last;
      bit [1:0] e;
      m_rise = dclk && !p_dclk;
      m_edge = dclk != p_dclk;
      m_clr  = (sel_n && !p_sel) || (!busy && p_busy);
      m_idle = ext_mode && (sel_n || !rd_conv);
      m_win  = ext_mode && !sel_n && rd_conv;
      last   = m_arm ? 18 : 17;
      if (m_clr) begin
        m_pos = 0;
        m_arm = m_edge && m_idle;
      end else begin
        if (m_edge && m_idle && m_pos == 0) m_arm = 1;
        else if (m_rise && m_win && m_pos < last) begin
          m_pos++;
          if (m_pos == (m_arm ? 2 : 1)) begin m_word = result_word; m_tag = tag_in; end
        end
      end
      last = m_arm ? 18 : 17;
      e = 2'b00;
      if (m_arm && m_pos == 1) e = 2'b01;
      else if (m_pos == last) e = {m_tag, 1'b0};
      else if (m_pos != 0) e = {m_word[16 - (m_pos - (m_arm ? 1 : 0))], 1'b0};
      exp_o = d2; d2 = d1; d1 = e;
      p_dclk = dclk; p_sel = sel_n; p_busy = busy;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({sdata, sync_out} !== exp_o) begin
        fails++;
        $display("FAIL %s t=%0t sdata/sync actual=%b%b expected=%b%b",
                 cur_req, $time, sdata, sync_out, exp_o[1], exp_o[0]);
      end
    end
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      wait_c(3); dclk = 1'b1;
      wait_c(3); dclk = 1'b0;
    end
  endtask

  task automatic toggle();
    wait_c(3); dclk = ~dclk;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    wait_c(4);
    // R1: outputs low in reset
    checks++;
    if (sdata !== 1'b0 || sync_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%b%b expected=00", sdata, sync_out);
    end
    rst_n = 1'b1;
    wait_c(6);

    // R2 R4 R8: plain read after conversion, tag taken at first rise
    cur_req = "R2 R4 R8";
    result_word = 16'hA5C3; tag_in = 1'b1;
    sel_n = 1'b0; wait_c(4);
    pulses(1); tag_in = 1'b0;
    pulses(19);
    wait_c(6);
    sel_n = 1'b1; wait_c(6);

    // R7 R8: arm with an idle pulse, tag taken at second rise
    cur_req = "R7 R8";
    result_word = 16'h3C96;
    pulses(1);
    sel_n = 1'b0; wait_c(4);
    tag_in = 1'b0; pulses(1);
    tag_in = 1'b1; pulses(1);
    tag_in = 1'b0; pulses(19);
    sel_n = 1'b1; wait_c(6);

    // R5: result changes after the MSB are not seen
    cur_req = "R5";
    sel_n = 1'b1; wait_c(4);
    result_word = 16'h8001;
    sel_n = 1'b0; wait_c(4);
    pulses(3);
    result_word = 16'h7FFE;
    pulses(16);
    sel_n = 1'b1; wait_c(6);

    // R3 R9: read/convert low stalls a frame mid-word, busy fall clears it
    cur_req = "R3 R9";
    result_word = 16'h1234; tag_in = 1'b1;
    sel_n = 1'b0; wait_c(4);
    pulses(5);
    rd_conv = 1'b0; wait_c(4);
    pulses(3);
    rd_conv = 1'b1; wait_c(4);
    pulses(4);
    rd_conv = 1'b0; wait_c(4);
    busy = 1'b0; wait_c(6);

    // R6: single edge with sel_n and rd_conv low arms SYNC (read during conversion)
    cur_req = "R6 R7";
    result_word = 16'hBEEF;
    toggle();
    wait_c(3);
    rd_conv = 1'b1; wait_c(4);
    toggle();
    pulses(19);
    busy = 1'b1; wait_c(6);

    // R9: sel_n rise mid-frame clears, then a fresh plain frame
    cur_req = "R9";
    sel_n = 1'b1; wait_c(6);
    sel_n = 1'b0; wait_c(4);
    result_word = 16'h0F0F;
    pulses(6);
    sel_n = 1'b1; wait_c(6);
    sel_n = 1'b0; wait_c(4);
    pulses(18);
    sel_n = 1'b1; wait_c(6);

    // R10: free-running data clock across chip-select changes
    cur_req = "R10";
    result_word = 16'h5AA5; tag_in = 1'b1;
    for (int i = 0; i < 90; i++) begin
      if (i == 4)  sel_n = 1'b0;
      if (i == 52) sel_n = 1'b1;
      if (i == 60) sel_n = 1'b0;
      toggle();
    end
    if (dclk) toggle();
    sel_n = 1'b1; wait_c(6);

    // R11: mode low ignores the data clock
    cur_req = "R11";
    ext_mode = 1'b0; wait_c(6);
    sel_n = 1'b0; wait_c(4);
    pulses(8);
    sel_n = 1'b1; wait_c(6);
    pulses(2);
    wait_c(6);
    ext_mode = 1'b1; wait_c(6);

    done = 1;
    summary();
    $finish;
  end
endmodule